// File: doc/BRIEF.md
# Programmable Periodic Interval Timer

This block divides the system clock down to a one-millisecond base and counts whole milliseconds against a software-set reload value. Each interval lasts (reload+1) milliseconds. When an interval ends, the block raises its interrupt output and starts the next interval at once, so it keeps firing periodically without any help from software.

The interrupt is level-held. It stays high until software acknowledges it, in one of two ways: a read of the acknowledge register, or a write of a new reload value. A reload write also restarts the interval, so the next expiry comes one full interval after that write.

Software reaches the block through a simple 32-bit register port that completes in a single cycle. Read data is combinational from the address. Word address 0 holds the reload value; word address 1 is the acknowledge register.

The interrupt side is a two-state machine:
- **QUIET**: the interrupt is low.
- **RAISED**: the interrupt is high.

Its transitions are:
- **FIRE**: QUIET to RAISED, on an expiry.
- **ACK**: RAISED to QUIET, on an acknowledge read with no expiry in the same cycle.
- **RELOAD**: from either state to QUIET, on a reload write.
- **HOLD**: stay in the current state otherwise. This includes RAISED seeing a further expiry, or an acknowledge read that coincides with an expiry.

Top module: `pit_timer`

## Requirements
- R1: During and directly after reset the interrupt is low, the reload register reads 0, and the first interval runs with reload 0.
- R2: Word address 0 is the reload register, readable and writable. Its value sits in bits [8:0]; written bits above bit 8 are dropped, and a read returns 0 in bits [31:9].
- R3: A write to word address 0 at clock edge E makes the interrupt rise right after edge E + (reload+1)·D, where D = CLK_HZ/1000; it stays low before that edge.
- R4: After each expiry the next interval of (reload+1)·D cycles begins at once, with no software action.
- R5: Once high, the interrupt stays high through later expiries until it is acknowledged.
- R6: A read of word address 1 returns 0 and, unless an expiry falls on the same edge, makes the interrupt low from the next cycle.
- R7: A reload write makes the interrupt low from the next cycle and restarts the interval, even when it falls on an expiry edge.
- R8: When an expiry and an acknowledge read fall on the same edge, the interrupt is high after that edge.
- R9: Accesses to word addresses 2 and 3 read 0, change neither the reload value nor the interrupt, and do not acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address of the access |
| req_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data for the current address (combinational) |
| irq | output | 1 | Level interrupt, held until acknowledged |

## Verification
A miscounted prescaler or millisecond counter shows on the first expiry after a reload write: the interrupt rises one or more cycles early or late. The bench pins the rising edge to the exact cycle for two reload values. A wrong interrupt-state transition shows one cycle after the offending edge: the interrupt drops when it should hold, or holds when it should drop. The bench provokes this with acknowledges and reloads placed exactly on expiry edges. A corrupted reload value shows on the next read of word address 0, and also in the spacing of later expiries.

// File: rtl/pit_pkg.sv
package pit_pkg;
    // interrupt state machine encoding
    typedef enum logic {
        ST_QUIET  = 1'b0,
        ST_RAISED = 1'b1
    } irq_state_e;

    // word addresses of the register port
    localparam int REG_RELOAD = 0;
    localparam int REG_ACK    = 1;
endpackage

// File: rtl/pit_prescaler.sv
// Divides the system clock down to a one-cycle pulse once per millisecond.
module pit_prescaler #(
    parameter int DIV = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_bypass
            logic unused_restart;
            assign unused_restart = restart;
            assign tick = 1'b1;
        end else begin : g_count
            localparam int CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] cnt;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt <= '0;
                end else if (restart || cnt == LAST) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end

            assign tick = (cnt == LAST);
        end
    endgenerate
endmodule

// File: rtl/pit_interval.sv
// Counts milliseconds left in the current interval; reloads itself on expiry.
module pit_interval #(
    parameter int RELOAD_W = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                restart,
    input  logic [RELOAD_W-1:0] load_val,
    input  logic [RELOAD_W-1:0] reload_q,
    output logic                expire
);
    logic [RELOAD_W-1:0] left;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left <= '0;
        end else if (restart) begin
            left <= load_val;
        end else if (tick) begin
            if (left == '0) begin
                left <= reload_q;
            end else begin
                left <= left - 1'b1;
            end
        end
    end

    // a restart in the same cycle cancels the expiry
    assign expire = tick && (left == '0) && !restart;
endmodule

// File: rtl/pit_regs.sv
// Register decode: reload register storage, acknowledge strobe, read mux.
module pit_regs
    import pit_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 2,
    parameter int RELOAD_W = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic [DATA_W-1:0]   rd_data,
    output logic [RELOAD_W-1:0] reload_q,
    output logic [RELOAD_W-1:0] load_val,
    output logic                wr_reload,
    output logic                rd_ack
);
    logic hit_reload;
    logic hit_ack;
    logic unused_hi;

    assign hit_reload = (req_addr == ADDR_W'(REG_RELOAD));
    assign hit_ack    = (req_addr == ADDR_W'(REG_ACK));
    assign wr_reload  = req_valid && req_write && hit_reload;
    assign rd_ack     = req_valid && !req_write && hit_ack;
    assign load_val   = req_wdata[RELOAD_W-1:0];
    assign unused_hi  = ^req_wdata[DATA_W-1:RELOAD_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= '0;
        end else if (wr_reload) begin
            reload_q <= load_val;
        end
    end

    always_comb begin
        rd_data = '0;
        if (hit_reload) begin
            rd_data[RELOAD_W-1:0] = reload_q;
        end
    end
endmodule

// File: rtl/pit_irq_fsm.sv
// Level interrupt state machine: FIRE / ACK / RELOAD / HOLD.
module pit_irq_fsm
    import pit_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic wr_reload,
    input  logic rd_ack,
    output logic irq
);
    irq_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_QUIET: begin
                if (wr_reload)   state_nx = ST_QUIET;   // RELOAD
                else if (expire) state_nx = ST_RAISED;  // FIRE
            end
            ST_RAISED: begin
                if (wr_reload)   state_nx = ST_QUIET;   // RELOAD
                else if (expire) state_nx = ST_RAISED;  // HOLD, expiry beats ack
                else if (rd_ack) state_nx = ST_QUIET;   // ACK
            end
            default: state_nx = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_QUIET;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        irq = (state == ST_RAISED);
    end
endmodule

// File: rtl/pit_timer.sv
// Top: programmable periodic interval timer.
module pit_timer #(
    parameter int CLK_HZ   = 100_000_000,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 2,
    parameter int RELOAD_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    localparam int DIV = CLK_HZ / 1000;

    logic [RELOAD_W-1:0] reload_q;
    logic [RELOAD_W-1:0] load_val;
    logic                wr_reload;
    logic                rd_ack;
    logic                tick;
    logic                expire;

    pit_regs #(
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W),
        .RELOAD_W(RELOAD_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .rd_data  (rd_data),
        .reload_q (reload_q),
        .load_val (load_val),
        .wr_reload(wr_reload),
        .rd_ack   (rd_ack)
    );

    pit_prescaler #(.DIV(DIV)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(wr_reload),
        .tick   (tick)
    );

    pit_interval #(.RELOAD_W(RELOAD_W)) u_ivl (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .restart (wr_reload),
        .load_val(load_val),
        .reload_q(reload_q),
        .expire  (expire)
    );

    pit_irq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .expire   (expire),
        .wr_reload(wr_reload),
        .rd_ack   (rd_ack),
        .irq      (irq)
    );
endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk
    import pit_pkg::*;
#(
    parameter int ADDR_W   = 2,
    parameter int RELOAD_W = 9
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_write,
    input logic [ADDR_W-1:0]   req_addr,
    input logic                irq,
    input logic                expire,
    input logic [RELOAD_W-1:0] reload_q
);
    logic wr_rl;
    logic rd_ak;
    assign wr_rl = req_valid && req_write && (req_addr == ADDR_W'(REG_RELOAD));
    assign rd_ak = req_valid && !req_write && (req_addr == ADDR_W'(REG_ACK));

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_low_chk: assert (!irq);
        end
    end

    // R7
    reload_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_rl |=> !irq);

    // R6
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ak && !expire && !wr_rl) |=> !irq);

    // R8
    expire_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !wr_rl) |=> irq);

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !rd_ak && !wr_rl) |=> irq);

    // R3
    rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(expire));

    // R9
    reload_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_rl |=> $stable(reload_q));
endmodule

bind pit_timer pit_timer_chk #(
    .ADDR_W  (ADDR_W),
    .RELOAD_W(RELOAD_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .irq      (irq),
    .expire   (expire),
    .reload_q (reload_q)
);

// File: tb/sim_pit_timer.sv
`timescale 1ns/1ps
module sim_pit_timer;
    localparam int CLK_HZ = 8000;
    localparam int D      = CLK_HZ / 1000;
    localparam int DW     = 32;
    localparam int AW     = 2;
    localparam int RW     = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    wire  [DW-1:0] rd_data;
    wire           irq;

    pit_timer #(.CLK_HZ(CLK_HZ), .DATA_W(DW), .ADDR_W(AW), .RELOAD_W(RW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data), .irq(irq)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        int    at;
        logic  val;
        string tag;
    } exp_t;
    exp_t sb[$];

    // driver side: push expected interrupt level for a future cycle
    task automatic expect_irq(input int at, input logic v, input string tag);
        exp_t e;
        e.at = at; e.val = v; e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor side: compare every item due in the current cycle
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].at == cyc) begin
                total++;
                if (irq !== sb[i].val) begin
                    bad++;
                    $display("FAIL %s irq at cycle %0d: actual=%b expected=%b",
                             sb[i].tag, cyc, irq, sb[i].val);
                end
                sb.delete(i);
            end
        end
    end

    task automatic check_val(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // one access, started at a negedge; returns at the next negedge
    task automatic op(input logic [AW-1:0] a, input bit wr, input logic [DW-1:0] d,
                      output logic [DW-1:0] rdv);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        #1 rdv = rd_data;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic to_cyc(input int t);
        if (cyc > t) begin
            total++; bad++;
            $display("FAIL schedule: actual=%0d expected<=%0d", cyc, t);
        end
        while (cyc < t) @(negedge clk);
    endtask

    initial begin
        logic [DW-1:0] r;
        int e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1 check_val("R1 irq after reset", {31'b0, irq}, 0);
        @(negedge clk);
        op(2'd0, 1'b0, '0, r);
        check_val("R1 reload reset value", r, 0);

        // R2: upper written bits dropped
        op(2'd0, 1'b1, 32'hFFFF_FFFF, r);
        op(2'd0, 1'b0, '0, r);
        check_val("R2 reload readback", r, 32'h0000_01FF);

        // R3: reload 2 -> interval 3*D
        op(2'd0, 1'b1, 32'd2, r);
        e = cyc;
        expect_irq(e + 3*D - 1, 1'b0, "R3");
        expect_irq(e + 3*D,     1'b1, "R3");
        expect_irq(e + 3*D + 5, 1'b1, "R5");
        expect_irq(e + 31,      1'b0, "R6");
        expect_irq(e + 6*D - 1, 1'b0, "R4");
        expect_irq(e + 6*D,     1'b1, "R4");
        to_cyc(e + 30);
        op(2'd1, 1'b0, '0, r);
        check_val("R6 ack read data", r, 0);

        expect_irq(e + 55, 1'b0, "R6");
        to_cyc(e + 54);
        op(2'd1, 1'b0, '0, r);

        // R8: ack on the third expiry edge
        expect_irq(e + 9*D - 1, 1'b0, "R8");
        expect_irq(e + 9*D,     1'b1, "R8");
        expect_irq(e + 9*D + 1, 1'b1, "R8");
        to_cyc(e + 9*D - 1);
        op(2'd1, 1'b0, '0, r);

        expect_irq(e + 81, 1'b0, "R6");
        to_cyc(e + 80);
        op(2'd1, 1'b0, '0, r);

        // R7: reload write on the fourth expiry edge
        expect_irq(e + 12*D,          1'b0, "R7");
        expect_irq(e + 12*D + 1,      1'b0, "R7");
        expect_irq(e + 12*D + D - 1,  1'b0, "R7");
        expect_irq(e + 12*D + D,      1'b1, "R7");
        expect_irq(e + 12*D + 2*D + 3, 1'b1, "R5");
        to_cyc(e + 12*D - 1);
        op(2'd0, 1'b1, 32'd0, r);

        // R9: other addresses
        expect_irq(e + 121, 1'b1, "R9");
        expect_irq(e + 122, 1'b1, "R9");
        expect_irq(e + 123, 1'b1, "R9");
        expect_irq(e + 124, 1'b1, "R9");
        to_cyc(e + 120);
        op(2'd3, 1'b1, 32'h0000_0155, r);
        op(2'd2, 1'b0, '0, r);
        check_val("R9 unused address reads 0", r, 0);
        op(2'd0, 1'b0, '0, r);
        check_val("R9 reload unchanged", r, 0);

        to_cyc(e + 130);
        total++;
        if (sb.size() != 0) begin
            bad++;
            $display("FAIL scoreboard pending: actual=%0d expected=0", sb.size());
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule